// File: doc/BRIEF.md
# Single-Wire Bus Memory Command Engine

This block is the function layer of a single-wire slave device. It runs once the network-address stage has picked this device. It takes bits one at a time from a bit-slot engine, assembles a command byte and then a start address byte, and carries out the command against a 256-byte register and memory map. The map is reached through a simple synchronous port whose read data arrives one cycle after the request. Bytes travel least significant bit first.

Two commands move data. Read streams bytes out of the map with no pause between them. Write takes bytes in and commits each one only when all eight of its bits have arrived. Three more commands, copy, recall and lock, pass a request to an EEPROM controller over a request/done handshake. They have no data phase. A bus reset from the bit engine ends any command. The EEPROM window is split into blocks. The controller reports which blocks are locked, and writes into a locked block are dropped.

Top module: `owmem_engine`

## Requirements
- R1: After `rst_n` and after every `bus_reset`, the engine is idle. It drives `tx_bit` high, raises neither `mem_rd` nor `mem_wr`, and waits for a `start` pulse.
- R2: Command 69h followed by address A streams the map out on `tx_bit`, least significant bit first, one bit per `tx_req` pulse. Bytes come from A, A+1, ... with no gap. Bit 0 of byte A+1 follows directly after bit 7 of byte A. `tx_req` pulses must be at least 3 cycles apart.
- R3: In a read, once the byte at FFh has been sent, every further bit is 1 until `bus_reset`.
- R4: Command 6Ch followed by address A stores each complete byte from `rx_bit` (least significant bit first) at A, A+1, .... The address advances even when a byte is not stored. Bytes sent after the one for FFh are dropped, and nothing wraps to 00h.
- R5: Writes to the read-only registers 08h..1Fh leave the map unchanged.
- R6: The EEPROM window 20h..3Fh consists of 16-byte blocks. Block k starts at 20h+16k. A write to block k is dropped while `lock_vec[k]` is 1.
- R7: A `bus_reset` in the middle of a byte discards that byte: nothing is written. The engine then accepts a new command.
- R8: Commands 48h, B8h and 6Ah with an address inside 20h..3Fh raise `ee_req` with `ee_op` 0, 1 and 2 respectively and `ee_addr` equal to the address. These hold steady until `ee_done`. `ee_req` is low from the cycle after `ee_done`. A `bus_reset` does not cancel a pending request.
- R9: An EEPROM command whose address lies outside 20h..3Fh, or that arrives while `ee_req` is still high, raises no new request.
- R10: Any other command byte causes no map access. `tx_bit` stays high until `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Bus reset pulse from the bit engine |
| start | input | 1 | Function phase begins (device selected) |
| rx_valid | input | 1 | A master-written bit is present |
| rx_bit | input | 1 | Bit written by the master |
| tx_req | input | 1 | Master read slot; consumes the current `tx_bit` |
| tx_bit | output | 1 | Bit offered for the next read slot |
| mem_addr | output | 8 | Map address |
| mem_rd | output | 1 | Map read strobe; data is expected one cycle later |
| mem_wr | output | 1 | Map write strobe |
| mem_wdata | output | 8 | Map write data |
| mem_rdata | input | 8 | Map read data |
| lock_vec | input | 2 | Per-block lock status from the EEPROM controller |
| ee_req | output | 1 | EEPROM operation request |
| ee_op | output | 2 | 0 copy, 1 recall, 2 lock |
| ee_addr | output | 8 | Address carried with the request |
| ee_done | input | 1 | EEPROM operation finished |

## Verification
The bench reads across the top of the map. A design that wrapped to 00h, or that fetched a byte too late at a byte boundary, would return map data where 1 bits are expected. It writes across the edge of the read-only range and the edge of a locked block. A design that stopped advancing the address on a dropped byte would put the next byte at the wrong place. It cuts a write off after three bits with a bus reset, which catches a design that commits partial bytes. It issues a bus reset and a second EEPROM command while a request is pending. A design that cancelled the request or overwrote its address would show a changed `ee_req`, `ee_op` or `ee_addr`.

// File: rtl/owmem_engine.sv
module owmem_engine #(
  parameter int RO_LO   = 8,
  parameter int RO_HI   = 31,
  parameter int EE_BASE = 32,
  parameter int EE_BLK  = 16,
  parameter int EE_NBLK = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_reset,
  input  logic               start,
  input  logic               rx_valid,
  input  logic               rx_bit,
  input  logic               tx_req,
  output logic               tx_bit,
  output logic [7:0]         mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic [EE_NBLK-1:0] lock_vec,
  output logic               ee_req,
  output logic [1:0]         ee_op,
  output logic [7:0]         ee_addr,
  input  logic               ee_done
);
  localparam int EE_TOP = EE_BASE + EE_BLK * EE_NBLK;
  localparam logic [7:0] C_RD = 8'h69, C_WR = 8'h6C, C_CP = 8'h48,
                         C_RC = 8'hB8, C_LK = 8'h6A;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_RD, S_WR, S_SINK} st_t;
  st_t st;

  logic [7:0] sh, cmd, ptr, nb;
  logic [2:0] cnt;
  logic       past, ld, adv;

  function automatic logic ro_hit(input logic [7:0] a);
    int ai = int'(a);
    return ai >= RO_LO && ai <= RO_HI;
  endfunction

  function automatic logic in_ee(input logic [7:0] a);
    int ai = int'(a);
    return ai >= EE_BASE && ai < EE_TOP;
  endfunction

  function automatic logic lock_hit(input logic [7:0] a, input logic [EE_NBLK-1:0] lv);
    int ai = int'(a);
    logic h = 1'b0;
    for (int k = 0; k < EE_NBLK; k++)
      if (lv[k] && ai >= EE_BASE + k * EE_BLK && ai < EE_BASE + (k + 1) * EE_BLK) h = 1'b1;
    return h;
  endfunction

  assign nb       = {rx_bit, sh[7:1]};
  assign mem_addr = ptr;
  assign tx_bit   = (st == S_RD) ? (past | sh[0]) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= 8'hFF; cmd <= 8'h00; ptr <= 8'h00; cnt <= 3'd0;
      past <= 1'b0; ld <= 1'b0; adv <= 1'b0;
      mem_rd <= 1'b0; mem_wr <= 1'b0; mem_wdata <= 8'h00;
      ee_req <= 1'b0; ee_op <= 2'd0; ee_addr <= 8'h00;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      adv    <= 1'b0;
      ld     <= mem_rd;
      if (ee_req && ee_done) ee_req <= 1'b0;
      if (bus_reset) begin
        st <= S_IDLE; cnt <= 3'd0; past <= 1'b0; ld <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (start) begin st <= S_CMD; cnt <= 3'd0; end
          S_CMD: if (rx_valid) begin
            sh  <= nb;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              cmd <= nb;
              st  <= (nb == C_RD || nb == C_WR || nb == C_CP || nb == C_RC || nb == C_LK)
                     ? S_ADDR : S_SINK;
            end
          end
          S_ADDR: if (rx_valid) begin
            sh  <= nb;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              ptr  <= nb;
              past <= 1'b0;
              if (cmd == C_RD) begin
                mem_rd <= 1'b1; st <= S_RD;
              end else if (cmd == C_WR) begin
                st <= S_WR;
              end else begin
                st <= S_SINK;
                if (in_ee(nb) && !ee_req) begin
                  ee_req  <= 1'b1;
                  ee_addr <= nb;
                  ee_op   <= (cmd == C_CP) ? 2'd0 : (cmd == C_RC) ? 2'd1 : 2'd2;
                end
              end
            end
          end
          S_RD: if (ld) begin
            sh <= mem_rdata;
          end else if (tx_req) begin
            sh  <= {1'b1, sh[7:1]};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7 && !past) begin
              if (ptr == 8'hFF) past <= 1'b1;
              else begin ptr <= ptr + 8'd1; mem_rd <= 1'b1; end
            end
          end
          S_WR: if (adv) begin
            if (ptr == 8'hFF) past <= 1'b1;
            else ptr <= ptr + 8'd1;
          end else if (rx_valid) begin
            sh  <= nb;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7 && !past) begin
              adv <= 1'b1;
              if (!ro_hit(ptr) && !lock_hit(ptr, lock_vec)) begin
                mem_wr <= 1'b1; mem_wdata <= nb;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_rw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_past_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past |=> tx_bit);
  assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !ro_hit(mem_addr));
  assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !mem_wr && !mem_rd);
  assert_ee_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_done) |=> ee_req && $stable(ee_addr) && $stable(ee_op));
  assert_ee_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && ee_done) |=> !ee_req);
  assert_ee_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_req) |-> in_ee(ee_addr));
endmodule

// File: tb/tb_owmem_engine.sv
module tb_owmem_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset = 0, start = 0, rx_valid = 0, rx_bit = 0, tx_req = 0, ee_done = 0;
  logic [1:0] lock_vec = 2'b00;
  logic tx_bit, mem_rd, mem_wr, ee_req;
  logic [7:0] mem_addr, mem_wdata, ee_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [1:0] ee_op;

  logic [7:0] ram [256];
  logic [7:0] exp_m [256];
  int checks = 0, failures = 0, bad_wr = 0, acc_cnt = 0, cyc = 0;
  bit watch_acc = 0;

  always #2 clk = ~clk;

  owmem_engine dut (.clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .start(start),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .tx_req(tx_req), .tx_bit(tx_bit),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .lock_vec(lock_vec), .ee_req(ee_req), .ee_op(ee_op),
    .ee_addr(ee_addr), .ee_done(ee_done));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram[mem_addr];
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_wr && ((mem_addr >= 8'h08 && mem_addr <= 8'h1F) ||
        (lock_vec[0] && mem_addr >= 8'h20 && mem_addr <= 8'h2F) ||
        (lock_vec[1] && mem_addr >= 8'h30 && mem_addr <= 8'h3F))) bad_wr++;
    if (watch_acc && (mem_rd || mem_wr)) acc_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cmp_mem(input string req);
    int mis = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== exp_m[i]) mis++;
    check(mis == 0, req, mis, 0);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); rx_bit = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); v[i] = tx_bit; tx_req = 1;
      @(negedge clk); tx_req = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_reset;
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic begin_cmd(input logic [7:0] c, input logic [7:0] a);
    pulse_reset();
    start = 1; @(negedge clk); start = 0;
    send_byte(c); send_byte(a);
  endtask

  function automatic bit writable(input int a);
    if (a >= 8 && a <= 31) return 0;
    if (a >= 32 && a <= 47 && lock_vec[0]) return 0;
    if (a >= 48 && a <= 63 && lock_vec[1]) return 0;
    return 1;
  endfunction

  task automatic write_seq(input logic [7:0] a, input logic [7:0] d [], input string req);
    int p = a;
    begin_cmd(8'h6C, a);
    foreach (d[i]) begin
      send_byte(d[i]);
      if (p <= 255 && writable(p)) exp_m[p] = d[i];
      p++;
    end
    repeat (3) @(negedge clk);
    cmp_mem(req);
  endtask

  task automatic ee_finish;
    @(negedge clk); ee_done = 1;
    @(negedge clk); ee_done = 0;
    check(ee_req == 0, "R8 done drop", ee_req, 0);
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin ram[i] = 8'((i * 37 + 11) & 255); exp_m[i] = ram[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(tx_bit == 1 && !mem_rd && !mem_wr && !ee_req, "R1 reset idle",
          {tx_bit, mem_rd, mem_wr, ee_req}, 4'b1000);

    begin_cmd(8'h69, 8'h10);
    for (int i = 0; i < 4; i++) begin
      read_byte(v);
      check(v == exp_m[16 + i], "R2 sequential read", v, exp_m[16 + i]);
    end

    begin_cmd(8'h69, 8'hFE);
    read_byte(v); check(v == exp_m[254], "R2 read FEh", v, exp_m[254]);
    read_byte(v); check(v == exp_m[255], "R2 read FFh", v, exp_m[255]);
    read_byte(v); check(v == 8'hFF, "R3 past top", v, 8'hFF);
    read_byte(v); check(v == 8'hFF, "R3 past top again", v, 8'hFF);

    write_seq(8'h02, '{8'hA5, 8'h3C, 8'h0F}, "R4 write sequence");
    begin_cmd(8'h69, 8'h02);
    read_byte(v); check(v == 8'hA5, "R4 readback", v, 8'hA5);

    write_seq(8'h06, '{8'h11, 8'h22, 8'h33, 8'h44}, "R5 ro edge");
    write_seq(8'h15, '{8'h99}, "R5 ro direct");

    lock_vec = 2'b10;
    write_seq(8'h2E, '{8'h5A, 8'h6B, 8'h7C, 8'h8D}, "R6 locked block");
    lock_vec = 2'b00;
    write_seq(8'h30, '{8'hC3}, "R6 unlocked block");

    begin_cmd(8'h6C, 8'h04);
    send_bit(1); send_bit(0); send_bit(1);
    pulse_reset();
    repeat (3) @(negedge clk);
    cmp_mem("R7 partial discarded");
    check(tx_bit == 1, "R7 idle after reset", tx_bit, 1);
    begin_cmd(8'h69, 8'h04);
    read_byte(v); check(v == exp_m[4], "R7 next command", v, exp_m[4]);

    write_seq(8'hFF, '{8'hE1, 8'hE2}, "R4 no wrap past top");

    begin_cmd(8'h48, 8'h25);
    @(negedge clk);
    check(ee_req == 1 && ee_op == 0 && ee_addr == 8'h25, "R8 copy request",
          {ee_req, ee_op, ee_addr}, {1'b1, 2'd0, 8'h25});
    pulse_reset();
    check(ee_req == 1, "R8 survives bus reset", ee_req, 1);
    begin_cmd(8'hB8, 8'h20);
    @(negedge clk);
    check(ee_op == 0 && ee_addr == 8'h25, "R9 busy ignores new", {ee_op, ee_addr}, {2'd0, 8'h25});
    ee_finish();

    begin_cmd(8'hB8, 8'h3A);
    @(negedge clk);
    check(ee_req == 1 && ee_op == 1 && ee_addr == 8'h3A, "R8 recall request",
          {ee_req, ee_op, ee_addr}, {1'b1, 2'd1, 8'h3A});
    ee_finish();
    begin_cmd(8'h6A, 8'h31);
    @(negedge clk);
    check(ee_req == 1 && ee_op == 2 && ee_addr == 8'h31, "R8 lock request",
          {ee_req, ee_op, ee_addr}, {1'b1, 2'd2, 8'h31});
    ee_finish();
    begin_cmd(8'h48, 8'h80);
    repeat (3) @(negedge clk);
    check(ee_req == 0, "R9 outside window", ee_req, 0);

    pulse_reset();
    watch_acc = 1;
    start = 1; @(negedge clk); start = 0;
    send_byte(8'h55); send_byte(8'h00); send_byte(8'h77);
    read_byte(v);
    check(v == 8'hFF, "R10 unknown command tx", v, 8'hFF);
    repeat (3) @(negedge clk);
    watch_acc = 0;
    check(acc_cnt == 0, "R10 no map access", acc_cnt, 0);
    cmp_mem("R10 map unchanged");

    check(bad_wr == 0, "R5 R6 illegal write strobes", bad_wr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule